// File: doc/BRIEF.md
# Two-Level Fair Bus Arbiter

This block is the central arbiter for a shared parallel bus with several masters, each wired to it through its own active-low request line and its own active-low grant line. Masters are split into two classes. The high class takes turns in a round-robin, and the low class as a whole occupies one extra seat in that same round-robin. Whenever that seat wins, the low masters take turns among themselves through a second round-robin. Heavy users therefore get frequent turns, and every low master is still served within a bounded number of rounds.

Arbitration runs alongside bus traffic. The arbiter watches the bus framing and initiator-ready strobes. It decides that the granted master has begun its transaction when the framing strobe goes active right after an idle cycle. From that point the grant is free to move to the next winner, even though the transaction is still running. When nobody requests, the grant stays parked on the last owner. That master can then start a transaction without raising its request line.

Masters `0 .. N_HI-1` form the high class and masters `N_HI .. N_HI+N_LO-1` form the low class. All strobes are active low.

Top module: `tla_arbiter`

## Requirements
- R1: After reset, exactly one bit of `gnt_n` is low in every cycle.
- R2: While `rst_n` is low at a clock edge, the grant goes to master 0 (`gnt_n` equals all ones except bit 0). The high rotation then resumes from master 1, and the low rotation resumes from its first member.
- R3: The grant does not move while its holder keeps its request low and has not yet started a transaction. This holds even if other masters are requesting and another master's transaction is running.
- R4: A start is recognised at a clock edge where `frame_n` is sampled low and the previous edge sampled both `frame_n` and `irdy_n` high. At that same edge the arbiter picks the next grant holder among the current requesters.
- R5: With masters 0 and 1 in the high class and masters 2, 3 and 4 in the low class, all requesting without pause, the transactions start in the order 0, 1, 2, 0, 1, 3, 0, 1, 4.
- R6: With only master 1 (high) and master 3 (low) requesting without pause, transactions alternate 1, 3, 1, 3.
- R7: When every request is high, `gnt_n` keeps its previous value. The parked master may start a transaction without a request, and the grant stays with it afterwards.
- R8: The low-class pointer moves only when a low master is granted. Grants to high masters leave it untouched.
- R9: The grant can move to a new master during a cycle in which `frame_n` is still low for the previous owner's transaction.
- R10: If the master that just started is the only requester, it is granted again for its next transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_n | input | N_HI+N_LO | Per-master request, active low; high class in the low-order bits |
| frame_n | input | 1 | Bus framing strobe, active low |
| irdy_n | input | 1 | Bus initiator-ready strobe, active low |
| gnt_n | output | N_HI+N_LO | Per-master grant, active low, registered |

## Verification
The assertions assume the masters follow the bus rules. Only the master that holds the grant may drive `frame_n` low, and only after it has seen an idle bus. A transaction always ends with a final phase in which `frame_n` is high and `irdy_n` is low, followed by an idle cycle. The bench keeps to this by modelling every master in one cycle-stepped routine. On the falling edge, that routine starts a transaction only for the current grant holder, and only when the strobes it drove at the last rising edge were both high. It then drives address, data and final phases, followed by a release to idle.

// File: rtl/tla_pkg.sv
package tla_pkg;

    // Outcome of one arbitration evaluation
    typedef enum logic [1:0] {
        DEC_HOLD = 2'd0,   // holder keeps the grant, waiting to start
        DEC_PARK = 2'd1,   // no requester, grant stays where it is
        DEC_NEW  = 2'd2    // a fresh winner is selected
    } tla_dec_e;

endpackage

// File: rtl/tla_rr_pick.sv
// Round-robin search: first set request at or after the pointer, wrapping.
module tla_rr_pick #(
    parameter int N  = 2,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        int cand;
        hit = 1'b0;
        idx = ptr;
        // scan farthest offset first so the nearest one wins last
        for (int off = N - 1; off >= 0; off--) begin
            cand = int'(ptr) + off;
            if (cand >= N) cand = cand - N;
            if (req[IW'(cand)]) begin
                hit = 1'b1;
                idx = IW'(cand);
            end
        end
    end
endmodule

// File: rtl/tla_bus_watch.sv
// Detects the first framing cycle that follows an idle bus cycle.
module tla_bus_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    output logic start_now
);
    logic idle_d, idle_q;

    always_comb begin
        idle_d = frame_n & irdy_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idle_q <= 1'b1;
        else        idle_q <= idle_d;
    end

    assign start_now = ~frame_n & idle_q;
endmodule

// File: rtl/tla_arbiter.sv
module tla_arbiter #(
    parameter int N_HI = 2,
    parameter int N_LO = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_HI+N_LO-1:0] req_n,
    input  logic                 frame_n,
    input  logic                 irdy_n,
    output logic [N_HI+N_LO-1:0] gnt_n
);
    import tla_pkg::*;

    localparam int N  = N_HI + N_LO;
    localparam int NS = N_HI + 1;                        // top-level seats
    localparam int TW = (NS > 1) ? $clog2(NS) : 1;
    localparam int LW = (N_LO > 1) ? $clog2(N_LO) : 1;
    localparam logic [TW-1:0] GRP_SEAT = TW'(N_HI);
    localparam logic [TW-1:0] LAST_HI  = TW'(N_HI - 1);
    localparam logic [LW-1:0] LAST_LO  = LW'(N_LO - 1);

    typedef struct packed {
        logic [N-1:0]  gnt;      // one-hot, active high
        logic [TW-1:0] tp;       // top-level seat searched first
        logic [LW-1:0] lp;       // low-class member searched first
        logic          started;  // current holder has begun its transaction
    } arb_st_t;

    arb_st_t  st_d, st_q;
    tla_dec_e dec;

    logic [N_HI-1:0] hi_req;
    logic [N_LO-1:0] lo_req;
    logic [NS-1:0]   seat_req;
    logic            seat_hit, lo_hit, start_now, holder_req;
    logic [TW-1:0]   seat_idx;
    logic [LW-1:0]   lo_idx;
    logic [N_LO-1:0] lo_hot;
    logic            holder_started;

    assign hi_req   = ~req_n[N_HI-1:0];
    assign lo_req   = ~req_n[N-1:N_HI];
    assign seat_req = {|lo_req, hi_req};

    tla_rr_pick #(.N(NS), .IW(TW)) u_top_pick (
        .req (seat_req),
        .ptr (st_q.tp),
        .hit (seat_hit),
        .idx (seat_idx)
    );

    tla_rr_pick #(.N(N_LO), .IW(LW)) u_lo_pick (
        .req (lo_req),
        .ptr (st_q.lp),
        .hit (lo_hit),
        .idx (lo_idx)
    );

    tla_bus_watch u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .irdy_n    (irdy_n),
        .start_now (start_now)
    );

    assign holder_req = |(st_q.gnt & ~req_n);
    assign lo_hot     = N_LO'(1) << lo_idx;

    always_comb begin
        st_d = st_q;
        if (holder_req && !st_q.started && !start_now) begin
            dec = DEC_HOLD;
        end else if (seat_hit) begin
            dec = DEC_NEW;
        end else begin
            dec = DEC_PARK;
        end

        case (dec)
            DEC_NEW: begin
                st_d.started = 1'b0;
                if (seat_idx != GRP_SEAT) begin
                    st_d.gnt = N'(1) << seat_idx;
                    st_d.tp  = (seat_idx == LAST_HI) ? GRP_SEAT : seat_idx + 1'b1;
                end else begin
                    st_d.gnt = {lo_hot, {N_HI{1'b0}}};
                    st_d.tp  = '0;
                    if (lo_hit) begin
                        st_d.lp = (lo_idx == LAST_LO) ? '0 : lo_idx + 1'b1;
                    end
                end
            end
            default: begin
                st_d.started = st_q.started | start_now;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.gnt     <= N'(1);
            st_q.tp      <= (N_HI > 1) ? TW'(1) : GRP_SEAT;
            st_q.lp      <= '0;
            st_q.started <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_n          = ~st_q.gnt;
    assign holder_started = st_q.started;
endmodule

// File: rtl/tla_arbiter_chk.sv
module tla_arbiter_chk #(
    parameter int N = 5
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req_n,
    input logic         frame_n,
    input logic [N-1:0] gnt_n,
    input logic         started
);
    // R1: a single grant in every cycle
    a_r1_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~gnt_n) == 1);

    // R2: leaving reset, master 0 holds the grant
    a_r2_reset_park: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (gnt_n == {{(N-1){1'b1}}, 1'b0}));

    // R3: a requesting holder that has not started keeps the grant
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (((~gnt_n & ~req_n) != '0) && !started && frame_n) |=> $stable(gnt_n));

    // R7: with no requests the grant stays parked
    a_r7_park: assert property (@(posedge clk) disable iff (!rst_n)
        (&req_n) |=> $stable(gnt_n));
endmodule

bind tla_arbiter tla_arbiter_chk #(.N(N_HI + N_LO)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_n   (req_n),
    .frame_n (frame_n),
    .gnt_n   (gnt_n),
    .started (holder_started)
);

// File: tb/tb_tla_arbiter.sv
module tb_tla_arbiter;
    localparam int NM = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NM-1:0] req_n = '1;
    logic          frame_n = 1'b1;
    logic          irdy_n = 1'b1;
    logic [NM-1:0] gnt_n;

    always #10 clk = ~clk;

    tla_arbiter #(.N_HI(2), .N_LO(3)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_n   (req_n),
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .gnt_n   (gnt_n)
    );

    int checks = 0;
    int errors = 0;
    int pend[NM];
    bit quiet[NM];
    bit busy;
    int ph;
    int dlen = 2;
    int order[64];
    int nstart;
    int onehot_bad;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int holder();
        for (int m = 0; m < NM; m++) if (!gnt_n[m]) return m;
        return -1;
    endfunction

    // One cycle of the master models, evaluated on the falling edge
    task automatic tick();
        @(negedge clk);
        if ($countones(~gnt_n) != 1) onehot_bad++;
        if (busy) begin
            if (ph > 0) begin
                irdy_n  = 1'b0;
                frame_n = (ph == 1);
                ph--;
            end else begin
                frame_n = 1'b1;
                irdy_n  = 1'b1;
                busy    = 1'b0;
            end
        end else if (frame_n && irdy_n) begin
            int h;
            h = holder();
            if (h >= 0 && pend[h] > 0) begin
                frame_n = 1'b0;
                irdy_n  = 1'b1;
                busy    = 1'b1;
                ph      = dlen;
                pend[h]--;
                if (nstart < 64) order[nstart] = h;
                nstart++;
            end
        end
        for (int m = 0; m < NM; m++) req_n[m] = !(pend[m] > 0 && !quiet[m]);
    endtask

    task automatic wait_starts(input int n);
        int guard;
        guard = 0;
        while (nstart < n && guard < 2000) begin
            tick();
            guard++;
        end
        chk(nstart >= n, "R1 progress (starts seen)", nstart, n);
        while (busy) tick();
        repeat (2) tick();
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        busy    = 1'b0;
        frame_n = 1'b1;
        irdy_n  = 1'b1;
        req_n   = '1;
        nstart  = 0;
        onehot_bad = 0;
        for (int m = 0; m < NM; m++) begin
            pend[m]  = 0;
            quiet[m] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(gnt_n == 5'b11110, "R2 grant during reset", gnt_n, 5'b11110);
        do_reset();
        tick();
        chk(gnt_n == 5'b11110, "R2 grant after reset", gnt_n, 5'b11110);
    endtask

    task automatic t_order();
        int exp9[9] = '{0, 1, 2, 0, 1, 3, 0, 1, 4};
        do_reset();
        dlen = 2;
        for (int m = 0; m < NM; m++) pend[m] = 100;
        wait_starts(9);
        for (int i = 0; i < 9; i++)
            chk(order[i] == exp9[i], "R5 start order all requesting", order[i], exp9[i]);
        chk(onehot_bad == 0, "R1 single grant per cycle", onehot_bad, 0);
    endtask

    task automatic t_pair();
        int exp4[4] = '{1, 3, 1, 3};
        do_reset();
        dlen = 3;
        pend[1] = 100;
        pend[3] = 100;
        wait_starts(4);
        for (int i = 0; i < 4; i++)
            chk(order[i] == exp4[i], "R6 alternation of two requesters", order[i], exp4[i]);
    endtask

    task automatic t_hold();
        int bad;
        do_reset();
        dlen = 6;
        pend[0] = 1;
        pend[1] = 1;
        pend[2] = 1;
        while (nstart < 1) tick();
        tick();
        // R4 R9: start edge has passed, frame still low, grant already on master 1
        chk(frame_n == 1'b0 && gnt_n == 5'b11101, "R9 R4 handover at start edge",
            gnt_n, 5'b11101);
        bad = 0;
        while (busy) begin
            tick();
            if (gnt_n != 5'b11101) bad++;
        end
        chk(bad == 0, "R3 waiting holder keeps grant", bad, 0);
        wait_starts(3);
        chk(order[1] == 1, "R3 waiting holder starts next", order[1], 1);
        chk(order[2] == 2, "R4 following grant after start", order[2], 2);
    endtask

    task automatic t_park();
        do_reset();
        dlen = 2;
        repeat (5) tick();
        chk(gnt_n == 5'b11110, "R7 parked on master 0 with no requests", gnt_n, 5'b11110);
        pend[1] = 1;
        wait_starts(1);
        chk(order[0] == 1, "R7 requester served", order[0], 1);
        chk(gnt_n == 5'b11101, "R7 parked on last owner", gnt_n, 5'b11101);
        quiet[1] = 1'b1;
        pend[1]  = 1;
        wait_starts(2);
        chk(order[1] == 1, "R7 parked master starts without request", order[1], 1);
        chk(gnt_n == 5'b11101, "R7 grant kept after unrequested start", gnt_n, 5'b11101);
    endtask

    task automatic t_ptr();
        do_reset();
        dlen = 1;
        pend[0] = 2;
        pend[1] = 2;
        pend[2] = 1;
        pend[3] = 1;
        wait_starts(6);
        chk(order[5] == 3, "R8 low class rotates to master 3", order[5], 3);
        pend[0] = 3;
        wait_starts(9);
        for (int i = 6; i < 9; i++)
            chk(order[i] == 0, "R10 sole requester granted again", order[i], 0);
        pend[2] = 1;
        pend[3] = 1;
        pend[4] = 1;
        wait_starts(12);
        chk(order[9] == 4, "R8 low pointer untouched by high grants", order[9], 4);
        chk(order[10] == 2, "R8 low rotation wraps", order[10], 2);
        chk(order[11] == 3, "R8 low rotation continues", order[11], 3);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", nstart, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_order();
        t_pair();
        t_hold();
        t_park();
        t_ptr();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule